// File: doc/BRIEF.md
# Parity-Checked Memory Bus Slave

This block is the backplane-facing slave logic of a memory board on an asynchronous 24-bit address, 16-bit data backplane. It compares the upper address bits and the address modifier code against the board's own window. It then turns each accepted data strobe into one request to a local memory arbiter. Transfers are a single byte (either lane) or a full word, as reads, writes or read-modify-write sequences. The bus inputs are assumed to be already synchronised to `clk`.

On a write, an odd-parity bit is generated for every byte lane and stored beside that byte in an 18-bit memory word. On a read, every enabled lane is checked against its stored bit. The cycle then ends with an acknowledge if all enabled lanes pass, or with a bus error if any enabled lane fails. A select indicator shows that the board owns a cycle. A sticky error indicator records the last parity failure until a later access ends cleanly.

Top module: `psb_slave`

## Requirements
- R1: An access is accepted only when `as_n_i` is low, at least one data strobe is low, `addr_i[23:20]` equals the base nibble (default 4'h3), and `am_i` is 6'h39 or 6'h3D. Any other cycle raises no memory request, no acknowledge and no bus error.
- R2: Strobe `ds_n_i[1]` (low) enables lane 1 = data bits 15:8 (even byte), and `ds_n_i[0]` enables lane 0 = bits 7:0 (odd byte). Both strobes give a word. `mem_be_o` carries the enabled lanes, `mem_addr_o` carries `addr_i[19:1]`, and a write changes only the enabled lanes.
- R3: In the memory word, lane i holds data in bits 9i+7:9i and parity in bit 9i+8. A written lane's parity makes the 9-bit lane's XOR equal 1 (odd parity), so a written 8'h00 stores parity 1.
- R4: A read whose enabled lanes all have odd parity ends with `ack_o` high and the stored bytes of the enabled lanes on `data_o`, with `data_oe_o` high.
- R5: A read ends with `berr_o` instead of `ack_o` if any enabled lane has even parity, including a stored byte 8'h00 with parity 0. A bad lane that is not enabled has no effect.
- R6: `sel_led_o` goes high in the cycle after an access is accepted. It stays high while `as_n_i` stays low, also between the phases of a read-modify-write, and falls within two cycles of `as_n_i` rising.
- R7: `err_led_o` is set by a cycle ending in bus error. It is kept through cycles not addressed to the board, and cleared by the next read or write that ends with acknowledge.
- R8: In a read-modify-write, `as_n_i` stays low across a read phase and a write phase. Each phase gets its own response, and the write phase regenerates parity so a failing word reads back clean afterwards.
- R9: `ack_o` and `berr_o` stay high until both strobes are high, fall in the next cycle, and are never high together.
- R10: `mem_req_o` stays high from acceptance until `mem_done_i`. No response is given before `mem_done_i`, and a write always ends with acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n_i | input | 1 | Address strobe, active low |
| ds_n_i | input | 2 | Data strobes, active low, one per byte lane |
| write_n_i | input | 1 | Low for write, high for read |
| addr_i | input | 23 | Bus address bits 23:1 |
| am_i | input | 6 | Address modifier code |
| data_i | input | 16 | Write data from the bus |
| data_o | output | 16 | Read data to the bus |
| data_oe_o | output | 1 | Read data valid / drive enable |
| ack_o | output | 1 | Data transfer acknowledge |
| berr_o | output | 1 | Bus error response |
| sel_led_o | output | 1 | Board select indicator |
| err_led_o | output | 1 | Sticky parity error indicator |
| mem_req_o | output | 1 | Request to the memory arbiter |
| mem_we_o | output | 1 | Request is a write |
| mem_be_o | output | 2 | Lane enables of the request |
| mem_addr_o | output | 19 | Word offset inside the board window |
| mem_wdata_o | output | 18 | Write word with per-lane parity |
| mem_rdata_i | input | 18 | Read word with per-lane parity |
| mem_done_i | input | 1 | One-cycle completion from the arbiter |

## Verification
The bench reads a word that was never written, where the all-zero byte with a zero parity bit must give a bus error. A design using even parity would acknowledge it instead. It corrupts one lane and then reads only the other lane; a checker that ignores the strobes would wrongly raise a bus error. It also runs a read-modify-write with the address strobe held low. A design that drops select between the phases, or that fails to regenerate parity on the write phase, would show a dark select indicator or a second bus error. Cycles outside the window, or with a foreign modifier, must leave the error indicator and the memory untouched. A decoder that checks too few bits would issue a memory request for them.

// File: rtl/psb_pkg.sv
package psb_pkg;

    localparam int BYTE_W = 8;

    // One stored byte lane: data plus its parity bit above it.
    typedef struct packed {
        logic              par;
        logic [BYTE_W-1:0] dat;
    } lane_t;

    localparam int LANE_W = $bits(lane_t);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_RESP = 2'd2
    } psb_state_e;

    // Parity bit that makes the nine-bit lane odd.
    function automatic logic odd_par(input logic [BYTE_W-1:0] d);
        return ~(^d);
    endfunction

    // A lane fails when its nine bits have even weight.
    function automatic logic par_fail(input lane_t l);
        return ~(^{l.par, l.dat});
    endfunction

endpackage

// File: rtl/psb_decode.sv
module psb_decode #(
    parameter int          ADDR_W   = 24,
    parameter int          DEC_BITS = 4,
    parameter logic [23:0] BASE     = 24'h300000,
    parameter int          AM_W     = 6,
    parameter logic [5:0]  AM_DATA  = 6'h39,
    parameter logic [5:0]  AM_SUPV  = 6'h3D
) (
    input  logic [ADDR_W-1:1] addr_i,
    input  logic [AM_W-1:0]   am_i,
    output logic              hit_o
);
    logic win_ok;
    logic am_ok;

    assign win_ok = (addr_i[ADDR_W-1 -: DEC_BITS] == BASE[ADDR_W-1 -: DEC_BITS]);
    assign am_ok  = (am_i == AM_DATA[AM_W-1:0]) || (am_i == AM_SUPV[AM_W-1:0]);
    assign hit_o  = win_ok && am_ok;
endmodule

// File: rtl/psb_lanes.sv
module psb_lanes
    import psb_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [LANES*BYTE_W-1:0] wdata_i,
    input  logic [LANES-1:0]        be_i,
    input  logic [LANES*LANE_W-1:0] rword_i,
    output logic [LANES*LANE_W-1:0] wword_o,
    output logic [LANES*BYTE_W-1:0] rdata_o,
    output logic                    bad_o
);
    logic [LANES-1:0] fail_v;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_t wl;
        lane_t rl;
        assign wl.dat = wdata_i[g*BYTE_W +: BYTE_W];
        assign wl.par = odd_par(wl.dat);
        assign wword_o[g*LANE_W +: LANE_W] = wl;
        assign rl = lane_t'(rword_i[g*LANE_W +: LANE_W]);
        assign rdata_o[g*BYTE_W +: BYTE_W] = rl.dat;
        assign fail_v[g] = be_i[g] & par_fail(rl);
    end

    assign bad_o = |fail_v;
endmodule

// File: rtl/psb_ctrl.sv
module psb_ctrl
    import psb_pkg::*;
#(
    parameter int LANES = 2,
    parameter int OFF_W = 19
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n_i,
    input  logic [LANES-1:0] ds_n_i,
    input  logic             write_n_i,
    input  logic             hit_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic             mem_done_i,
    input  logic             rbad_i,
    output logic             start_o,
    output logic             rd_load_o,
    output logic             mem_req_o,
    output logic             mem_we_o,
    output logic [LANES-1:0] mem_be_o,
    output logic [OFF_W-1:0] mem_off_o,
    output logic             ack_o,
    output logic             berr_o,
    output logic             data_oe_o,
    output logic             sel_o,
    output logic             err_o
);
    psb_state_e       st;
    logic             we_q;
    logic [LANES-1:0] be_q;
    logic [OFF_W-1:0] off_q;
    logic             fail_q;
    logic             owned_q;
    logic             err_q;
    logic             ds_any;
    logic             ds_none;

    assign ds_any  = ~(&ds_n_i);
    assign ds_none = &ds_n_i;
    assign start_o = (st == ST_IDLE) && !as_n_i && ds_any && hit_i;
    assign rd_load_o = (st == ST_MEM) && mem_done_i && !we_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            we_q    <= 1'b0;
            be_q    <= '0;
            off_q   <= '0;
            fail_q  <= 1'b0;
            owned_q <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_o) begin
                        st      <= ST_MEM;
                        we_q    <= ~write_n_i;
                        be_q    <= ~ds_n_i;
                        off_q   <= off_i;
                        owned_q <= 1'b1;
                    end else if (as_n_i) begin
                        owned_q <= 1'b0;
                    end
                end
                ST_MEM: begin
                    if (mem_done_i) begin
                        st     <= ST_RESP;
                        fail_q <= !we_q && rbad_i;
                        err_q  <= !we_q && rbad_i;
                    end
                end
                ST_RESP: begin
                    if (ds_none) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req_o = (st == ST_MEM);
    assign mem_we_o  = we_q;
    assign mem_be_o  = be_q;
    assign mem_off_o = off_q;
    assign ack_o     = (st == ST_RESP) && !fail_q;
    assign berr_o    = (st == ST_RESP) && fail_q;
    assign data_oe_o = (st == ST_RESP) && !we_q;
    assign sel_o     = owned_q;
    assign err_o     = err_q;
endmodule

// File: rtl/psb_slave.sv
module psb_slave
    import psb_pkg::*;
#(
    parameter int          ADDR_W   = 24,
    parameter int          DATA_W   = 16,
    parameter int          DEC_BITS = 4,
    parameter logic [23:0] BASE     = 24'h300000,
    parameter logic [5:0]  AM_DATA  = 6'h39,
    parameter logic [5:0]  AM_SUPV  = 6'h3D,
    localparam int         LANES    = DATA_W / BYTE_W,
    localparam int         OFF_W    = ADDR_W - DEC_BITS - 1,
    localparam int         WORD_W   = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              as_n_i,
    input  logic [LANES-1:0]  ds_n_i,
    input  logic              write_n_i,
    input  logic [ADDR_W-1:1] addr_i,
    input  logic [5:0]        am_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              data_oe_o,
    output logic              ack_o,
    output logic              berr_o,
    output logic              sel_led_o,
    output logic              err_led_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [LANES-1:0]  mem_be_o,
    output logic [OFF_W-1:0]  mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              mem_done_i
);
    logic              hit;
    logic              start;
    logic              rd_load;
    logic              rbad;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rdata_raw;

    psb_decode #(
        .ADDR_W(ADDR_W), .DEC_BITS(DEC_BITS), .BASE(BASE),
        .AM_W(6), .AM_DATA(AM_DATA), .AM_SUPV(AM_SUPV)
    ) u_dec (
        .addr_i(addr_i), .am_i(am_i), .hit_o(hit)
    );

    psb_ctrl #(.LANES(LANES), .OFF_W(OFF_W)) u_ctrl (
        .clk(clk), .rst(rst),
        .as_n_i(as_n_i), .ds_n_i(ds_n_i), .write_n_i(write_n_i),
        .hit_i(hit), .off_i(addr_i[OFF_W:1]),
        .mem_done_i(mem_done_i), .rbad_i(rbad),
        .start_o(start), .rd_load_o(rd_load),
        .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_be_o(mem_be_o),
        .mem_off_o(mem_addr_o),
        .ack_o(ack_o), .berr_o(berr_o), .data_oe_o(data_oe_o),
        .sel_o(sel_led_o), .err_o(err_led_o)
    );

    psb_lanes #(.LANES(LANES)) u_lanes (
        .wdata_i(wdata_q), .be_i(mem_be_o), .rword_i(mem_rdata_i),
        .wword_o(mem_wdata_o), .rdata_o(rdata_raw), .bad_o(rbad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start)   wdata_q <= data_i;
            if (rd_load) rdata_q <= rdata_raw;
        end
    end

    assign data_o = rdata_q;
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
    parameter int LANES = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [LANES-1:0] ds_n_i,
    input logic             ack_o,
    input logic             berr_o,
    input logic             sel_led_o,
    input logic             err_led_o,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [LANES*9-1:0] mem_wdata_o,
    input logic             mem_done_i
);
    AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ack_o && berr_o)); // R9

    AST_ACK_HELD_TO_DS: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_o) |-> $past(&ds_n_i)); // R9

    AST_BERR_HELD_TO_DS: assert property (@(posedge clk) disable iff (rst)
        $fell(berr_o) |-> $past(&ds_n_i)); // R9

    AST_RESP_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ($rose(ack_o) || $rose(berr_o)) |-> $past(mem_done_i)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o && !mem_done_i) |=> mem_req_o); // R10

    AST_BERR_LIGHTS_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(berr_o) |-> err_led_o); // R7

    AST_ACK_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> !err_led_o); // R7

    AST_SEL_COVERS_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req_o || ack_o || berr_o) |-> sel_led_o); // R6

    for (genvar g = 0; g < LANES; g++) begin : g_par
        AST_WRITE_ODD_PARITY: assert property (@(posedge clk) disable iff (rst)
            (mem_req_o && mem_we_o) |-> (^mem_wdata_o[g*9 +: 9])); // R3
    end
endmodule

bind psb_slave psb_checker #(.LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .ds_n_i(ds_n_i),
    .ack_o(ack_o), .berr_o(berr_o), .sel_led_o(sel_led_o), .err_led_o(err_led_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o),
    .mem_done_i(mem_done_i)
);

// File: tb/sim_psb_slave.sv
`timescale 1ns/1ps
module sim_psb_slave;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        as_n = 1'b1;
    logic [1:0]  ds_n = 2'b11;
    logic        write_n = 1'b1;
    logic [23:1] addr = '0;
    logic [5:0]  am = 6'h39;
    logic [15:0] wdat = '0;
    logic [15:0] rdat;
    logic        oe, ack, berr, sel, errl, req, we;
    logic [1:0]  be;
    logic [18:0] maddr;
    logic [17:0] mwdata;
    logic [17:0] mrdata = '0;
    logic        mdone = 1'b0;

    int unsigned checks = 0;
    int unsigned fails = 0;
    int unsigned reqs = 0;
    int unsigned cyc = 0;
    int          lat = 1;
    int          lat_cnt = 0;

    logic [17:0] mem [256];
    logic [15:0] shadow [256];
    logic [1:0]  badf [256];
    logic        err_exp = 1'b0;

    always #5 clk = ~clk;

    psb_slave u0 (
        .clk(clk), .rst(rst), .as_n_i(as_n), .ds_n_i(ds_n), .write_n_i(write_n),
        .addr_i(addr), .am_i(am), .data_i(wdat), .data_o(rdat), .data_oe_o(oe),
        .ack_o(ack), .berr_o(berr), .sel_led_o(sel), .err_led_o(errl),
        .mem_req_o(req), .mem_we_o(we), .mem_be_o(be), .mem_addr_o(maddr),
        .mem_wdata_o(mwdata), .mem_rdata_i(mrdata), .mem_done_i(mdone)
    );

    // Memory arbiter model with a variable latency.
    always @(posedge clk) begin
        if (mdone) begin
            mdone <= 1'b0;
            lat_cnt <= 0;
        end else if (req) begin
            if (lat_cnt >= lat) begin
                for (int i = 0; i < 2; i++)
                    if (we && be[i]) mem[maddr[7:0]][i*9 +: 9] <= mwdata[i*9 +: 9];
                mrdata <= mem[maddr[7:0]];
                mdone  <= 1'b1;
                reqs   <= reqs + 1;
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            summary();
        end
    end

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // One bus access; off is the word index, lanes are active-high enables
    // (bit 1 = bits 15:8, bit 0 = bits 7:0).
    task automatic access(input bit wr, input bit in_win, input logic [5:0] amc,
                          input logic [7:0] off, input logic [1:0] lanes,
                          input logic [15:0] wd, input bit keep_as);
        bit          hit_exp;
        bit          berr_exp;
        bit          got;
        logic [15:0] rd;
        logic [15:0] mask;
        int unsigned req0;
        hit_exp  = in_win && (amc == 6'h39 || amc == 6'h3D);
        berr_exp = !wr && ((lanes & badf[off]) != 2'b00);
        mask     = {{8{lanes[1]}}, {8{lanes[0]}}};
        req0     = reqs;
        @(negedge clk);
        as_n = 1'b0;
        addr = {(in_win ? 4'h3 : 4'h4), 11'h000, off};
        am = amc;
        write_n = !wr;
        wdat = wd;
        ds_n = ~lanes;
        got = 1'b0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (ack || berr) begin got = 1'b1; break; end
        end
        if (!hit_exp) begin
            check(!got, "R1 no response outside window", {ack, berr}, 0);
            check(reqs == req0, "R1 no memory request", reqs - req0, 0);
            check(sel == 1'b0, "R6 select dark when not addressed", sel, 0);
            check(errl == err_exp, "R7 error indicator kept", errl, err_exp);
        end else begin
            check(got, "R10 response given", got, 1);
            check(berr == berr_exp && ack == !berr_exp, "R5 response kind",
                  {ack, berr}, {!berr_exp, berr_exp});
            check(sel == 1'b1, "R6 select lit during cycle", sel, 1);
            err_exp = berr_exp;
            check(errl == err_exp, "R7 error indicator", errl, err_exp);
            if (!wr && !berr_exp) begin
                rd = rdat;
                check(oe && ((rd & mask) == (shadow[off] & mask)), "R4 read data",
                      rd & mask, shadow[off] & mask);
            end
            // Response must hold while strobes stay low.
            @(negedge clk);
            check(ack == !berr_exp && berr == berr_exp, "R9 response held", {ack, berr},
                  {!berr_exp, berr_exp});
        end
        ds_n = 2'b11;
        if (!keep_as) as_n = 1'b1;
        @(negedge clk);
        check(!ack && !berr, "R9 response released", {ack, berr}, 0);
        @(negedge clk);
        if (hit_exp) begin
            if (keep_as) check(sel == 1'b1, "R6 select held between phases", sel, 1);
            else         check(sel == 1'b0, "R6 select falls after strobe", sel, 0);
        end
        if (hit_exp && wr) begin
            for (int i = 0; i < 2; i++) begin
                if (lanes[i]) begin
                    shadow[off][i*8 +: 8] = wd[i*8 +: 8];
                    badf[off][i] = 1'b0;
                    check(mem[off][i*9 +: 8] == wd[i*8 +: 8], "R2 lane stored",
                          mem[off][i*9 +: 8], wd[i*8 +: 8]);
                    check(^mem[off][i*9 +: 9] == 1'b1, "R3 odd parity stored",
                          mem[off][i*9 +: 9], {~^wd[i*8 +: 8], wd[i*8 +: 8]});
                end else begin
                    check(mem[off][i*9 +: 8] == shadow[off][i*8 +: 8], "R2 other lane untouched",
                          mem[off][i*9 +: 8], shadow[off][i*8 +: 8]);
                end
            end
        end
    endtask

    task automatic corrupt(input logic [7:0] off, input int lane);
        mem[off][lane*9 + 8] = ~mem[off][lane*9 + 8];
        badf[off][lane] = ~badf[off][lane];
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            mem[i] = '0;
            shadow[i] = '0;
            badf[i] = 2'b11;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!ack && !berr && !sel && !errl && !req, "R9 reset state",
              {ack, berr, sel, errl, req}, 0);

        // Never-written word: zero byte with zero parity bit.
        access(0, 1, 6'h39, 8'd5, 2'b11, 16'h0, 0);
        access(0, 0, 6'h39, 8'd5, 2'b11, 16'h0, 0);   // other window
        access(0, 1, 6'h2D, 8'd5, 2'b11, 16'h0, 0);   // foreign modifier
        access(1, 1, 6'h3D, 8'd5, 2'b11, 16'hA55A, 0);
        access(0, 1, 6'h39, 8'd5, 2'b11, 16'h0, 0);
        // Byte writes and partial reads.
        access(1, 1, 6'h39, 8'd6, 2'b10, 16'h7E00, 0);
        access(0, 1, 6'h39, 8'd6, 2'b10, 16'h0, 0);
        access(0, 1, 6'h39, 8'd6, 2'b11, 16'h0, 0);
        // Bad lane not enabled is ignored.
        corrupt(8'd5, 0);
        access(0, 1, 6'h39, 8'd5, 2'b10, 16'h0, 0);
        access(0, 1, 6'h39, 8'd5, 2'b01, 16'h0, 0);
        // Read-modify-write over a failing word.
        access(0, 1, 6'h39, 8'd5, 2'b11, 16'h0, 1);
        access(1, 1, 6'h39, 8'd5, 2'b11, 16'h1234, 0);
        access(0, 1, 6'h39, 8'd5, 2'b11, 16'h0, 0);     // R8 clean after rewrite
        // Zero data written gets parity 1.
        access(1, 1, 6'h39, 8'd7, 2'b11, 16'h0000, 0);
        access(0, 1, 6'h39, 8'd7, 2'b11, 16'h0, 0);

        for (int n = 0; n < 400; n++) begin
            logic [7:0] off;
            logic [1:0] ln;
            int         op;
            off = 8'($urandom_range(0, 31));
            ln  = 2'($urandom_range(1, 3));
            lat = $urandom_range(0, 4);
            op  = $urandom_range(0, 9);
            if (op == 0) corrupt(off, $urandom_range(0, 1));
            if (op == 1)      access(0, 0, 6'h39, off, ln, 16'h0, 0);
            else if (op == 2) access(0, 1, 6'h09, off, ln, 16'h0, 0);
            else if (op == 3) begin
                access(0, 1, 6'h39, off, ln, 16'h0, 1);
                access(1, 1, 6'h39, off, ln, 16'($urandom), 0);
            end else if (op < 7) access(1, 1, ($urandom_range(0, 1) != 0) ? 6'h39 : 6'h3D,
                                        off, ln, 16'($urandom), 0);
            else access(0, 1, 6'h39, off, ln, 16'h0, 0);
        end
        summary();
    end
endmodule